// File: doc/BRIEF.md
# Hamming ECC syndrome corrector

This block checks one or more 512-byte data blocks. Each block is protected by a 3-byte Hamming code of the row and column parity type, which corrects one bit and detects two. For every block the block receives two codes: the code that was kept in the spare area and the code that the parity generator computed while the data was read. Both codes arrive in the generator's packed layout. The block unpacks them into even and odd parity pairs and moves the pairs into the on-flash byte order. It XORs the two results to form a 24-bit syndrome and classifies the syndrome by how many of its bits are set.

A caller places the codes on the inputs and pulses `start_i`. One cycle later `valid_o` pulses and the registered results appear. For each block there is a two-bit state. When a single data bit is wrong, there is also the byte offset and the bit index of that bit, so the caller can flip it in its own buffer. Across the active blocks the block reports the number of corrected blocks, or a failure flag if any active block cannot be corrected.

A multi-block mode checks every block of a 2048-byte page, each with its own code. The single-block mode checks only block 0.

Top module: `hamming_fix_unit`

## Requirements
- R1: While reset is held and after it is released, `valid_o`, `fail_o`, `fix_count_o`, `sub_state_o`, `byte_ofs_o` and `bit_idx_o` are all zero.
- R2: A `start_i` sampled at a clock edge updates every result at that edge. `valid_o` is high for exactly the following cycle. The results then hold unchanged until the next `start_i`.
- R3: The block-state encoding is 0 clean, 1 corrected, 2 error in the stored code only, 3 uncorrectable. Block k uses code bits [24k+23:24k] (byte0 in [7:0], byte1 in [15:8], byte2 in [23:16]) and state bits [2k+1:2k]. Equal stored and computed codes give state 0.
- R4: Code layout: byte0 is raw bits 0-7, byte2[3:0] is raw bits 8-11, byte1 is raw bits 16-23 and byte2[7:4] is raw bits 24-27. Raw bit j (j<12) covers the data bits whose 12-bit address (byte*8+bit) has bit j clear. Raw bit 16+j covers those with bit j set. A single flipped data bit at address A gives state 1, byte offset A/8 (9 bits) and bit index A%8 (3 bits).
- R5: A code pair that differs in exactly one code bit gives state 2.
- R6: A syndrome whose set-bit count is not 0, 1 or 12 gives state 3. Two flipped data bits that differ in one address bit are an example.
- R7: A stored code of 0xFFFFFF together with a computed code of 0x000000 is reported as state 0 (an erased page).
- R8: `fix_count_o` is the number of active blocks in state 1. When any active block is in state 3, `fail_o` is 1 and `fix_count_o` is 0.
- R9: With `multi_i` low, only block 0 is checked. Blocks 1 and up report state 0, offset 0 and index 0 whatever their codes.
- R10: The byte offset and bit index of a block are zero unless that block is in state 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Evaluate the codes present this cycle |
| multi_i | input | 1 | 1: check all blocks; 0: check block 0 only |
| stored_i | input | 24*SUB_BLOCKS | Codes read from the spare area |
| calc_i | input | 24*SUB_BLOCKS | Codes computed from the read data |
| valid_o | output | 1 | One-cycle pulse marking new results |
| fail_o | output | 1 | Some active block is uncorrectable |
| fix_count_o | output | clog2(SUB_BLOCKS+1) | Number of corrected blocks |
| sub_state_o | output | 2*SUB_BLOCKS | Per-block state |
| byte_ofs_o | output | 9*SUB_BLOCKS | Per-block byte offset of the wrong bit |
| bit_idx_o | output | 3*SUB_BLOCKS | Per-block bit index of the wrong bit |

## Verification
The hardest case to reach from the ports is a syndrome with exactly twelve set bits that points to a chosen address. Random code pairs almost never produce such a count. The bench therefore builds each computed code from a stored code by toggling the raw parity bits that one flipped data bit at address A would change. It does this for all 4096 addresses of block 0. The same construction with two addresses yields the double-error counts, and a single toggled code bit yields the stored-code-only case.

// File: rtl/hamming_fix_pkg.sv
package hamming_fix_pkg;
   localparam int ADDR_W = 12;           // bit address width of a 512-byte block
   localparam int CODE_W = 2 * ADDR_W;   // one even and one odd parity per address bit
   localparam int RAW_W  = 28;           // packed generator word
   localparam int OFS_W  = ADDR_W - 3;
   localparam int IDX_W  = 3;
   localparam int WGT_W  = $clog2(CODE_W + 1);

   typedef enum logic [1:0] {
      ST_CLEAN = 2'd0,
      ST_FIXED = 2'd1,
      ST_CODE  = 2'd2,
      ST_BAD   = 2'd3
   } fix_state_e;

   // spread the 3 code bytes into the generator word: evens low, odds high
   function automatic logic [RAW_W-1:0] unpack_raw(input logic [CODE_W-1:0] c);
      logic [RAW_W-1:0] r;
      r        = '0;
      r[7:0]   = c[7:0];
      r[11:8]  = c[19:16];
      r[23:16] = c[15:8];
      r[27:24] = c[23:20];
      return r;
   endfunction

   // place each even/odd pair at its on-flash position, then invert
   function automatic logic [CODE_W-1:0] to_flash(input logic [RAW_W-1:0] r);
      logic [CODE_W-1:0] t;
      int pos;
      t = '0;
      for (int j = 0; j < ADDR_W; j++) begin
         if (j >= 3 && j <= 10)  pos = 2 * (j - 3);
         else if (j == 11)       pos = 16;
         else                    pos = 18 + 2 * j;
         t[pos]   = r[j];
         t[pos+1] = r[16+j];
      end
      return ~t;
   endfunction

   // syndrome order: byte2[7:2], byte0, byte1, byte2[1:0]
   function automatic logic [CODE_W-1:0] form_syndrome(input logic [CODE_W-1:0] d);
      logic [CODE_W-1:0] s;
      s[5:0]   = d[23:18];
      s[13:6]  = d[7:0];
      s[21:14] = d[15:8];
      s[23:22] = d[17:16];
      return s;
   endfunction
endpackage

// File: rtl/hamming_fix_syndrome.sv
module hamming_fix_syndrome
   import hamming_fix_pkg::*;
(
   input  logic [CODE_W-1:0] stored_i,
   input  logic [CODE_W-1:0] calc_i,
   output logic [CODE_W-1:0] synd_o,
   output logic              erased_o
);
   logic [CODE_W-1:0] flash_st, flash_cl;

   assign flash_st = to_flash(unpack_raw(stored_i));
   assign flash_cl = to_flash(unpack_raw(calc_i));
   assign synd_o   = form_syndrome(flash_st ^ flash_cl);
   assign erased_o = (stored_i == '1) && (calc_i == '0);
endmodule

// File: rtl/hamming_fix_classify.sv
module hamming_fix_classify
   import hamming_fix_pkg::*;
#(
   parameter bit ERASED_FIX = 1'b1
) (
   input  logic [CODE_W-1:0] synd_i,
   input  logic              erased_i,
   input  logic              active_i,
   output fix_state_e        state_o,
   output logic [OFS_W-1:0]  ofs_o,
   output logic [IDX_W-1:0]  idx_o
);
   logic [WGT_W-1:0]  weight;
   logic [ADDR_W-1:0] odd_bits;
   logic              erased_ok;

   assign weight = WGT_W'($countones(synd_i));

   for (genvar j = 0; j < ADDR_W; j++) begin : g_odd
      assign odd_bits[j] = synd_i[2*j+1];
   end

   if (ERASED_FIX) begin : g_erased
      assign erased_ok = erased_i;
   end else begin : g_no_erased
      assign erased_ok = 1'b0;
   end

   always_comb begin
      state_o = ST_CLEAN;
      ofs_o   = '0;
      idx_o   = '0;
      if (active_i && !erased_ok) begin
         if (weight == WGT_W'(0))            state_o = ST_CLEAN;
         else if (weight == WGT_W'(1))       state_o = ST_CODE;
         else if (weight == WGT_W'(ADDR_W)) begin
            state_o = ST_FIXED;
            ofs_o   = odd_bits[ADDR_W-1:IDX_W];
            idx_o   = odd_bits[IDX_W-1:0];
         end else                            state_o = ST_BAD;
      end
   end
endmodule

// File: rtl/hamming_fix_unit.sv
module hamming_fix_unit
   import hamming_fix_pkg::*;
#(
   parameter int SUB_BLOCKS = 4,
   parameter bit ERASED_FIX = 1'b1,
   localparam int CNT_W = $clog2(SUB_BLOCKS + 1)
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic                         start_i,
   input  logic                         multi_i,
   input  logic [SUB_BLOCKS*CODE_W-1:0] stored_i,
   input  logic [SUB_BLOCKS*CODE_W-1:0] calc_i,
   output logic                         valid_o,
   output logic                         fail_o,
   output logic [CNT_W-1:0]             fix_count_o,
   output logic [SUB_BLOCKS*2-1:0]      sub_state_o,
   output logic [SUB_BLOCKS*OFS_W-1:0]  byte_ofs_o,
   output logic [SUB_BLOCKS*IDX_W-1:0]  bit_idx_o
);
   if (SUB_BLOCKS < 1) begin : g_bad_cfg
      $error("SUB_BLOCKS must be at least 1");
   end

   fix_state_e                   st_c [SUB_BLOCKS];
   logic [SUB_BLOCKS*2-1:0]      st_flat_c;
   logic [SUB_BLOCKS*OFS_W-1:0]  ofs_c;
   logic [SUB_BLOCKS*IDX_W-1:0]  idx_c;

   for (genvar k = 0; k < SUB_BLOCKS; k++) begin : g_blk
      logic [CODE_W-1:0] synd;
      logic              erased;
      logic              active;

      assign active = (k == 0) || multi_i;

      hamming_fix_syndrome syn_i (
         .stored_i (stored_i[k*CODE_W +: CODE_W]),
         .calc_i   (calc_i[k*CODE_W +: CODE_W]),
         .synd_o   (synd),
         .erased_o (erased)
      );

      hamming_fix_classify #(.ERASED_FIX(ERASED_FIX)) cls_i (
         .synd_i   (synd),
         .erased_i (erased),
         .active_i (active),
         .state_o  (st_c[k]),
         .ofs_o    (ofs_c[k*OFS_W +: OFS_W]),
         .idx_o    (idx_c[k*IDX_W +: IDX_W])
      );

      assign st_flat_c[k*2 +: 2] = st_c[k];
   end

   logic             any_bad_c;
   logic [CNT_W-1:0] n_fix_c;

   always_comb begin
      any_bad_c = 1'b0;
      n_fix_c   = '0;
      for (int k = 0; k < SUB_BLOCKS; k++) begin
         if (st_c[k] == ST_BAD)   any_bad_c = 1'b1;
         if (st_c[k] == ST_FIXED) n_fix_c   = n_fix_c + CNT_W'(1);
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         valid_o     <= 1'b0;
         fail_o      <= 1'b0;
         fix_count_o <= '0;
         sub_state_o <= '0;
         byte_ofs_o  <= '0;
         bit_idx_o   <= '0;
      end else begin
         valid_o <= start_i;
         if (start_i) begin
            fail_o      <= any_bad_c;
            fix_count_o <= any_bad_c ? '0 : n_fix_c;
            sub_state_o <= st_flat_c;
            byte_ofs_o  <= ofs_c;
            bit_idx_o   <= idx_c;
         end
      end
   end
endmodule

// File: rtl/hamming_fix_chk.sv
module hamming_fix_chk
   import hamming_fix_pkg::*;
#(
   parameter int SUB_BLOCKS = 4,
   localparam int CNT_W = $clog2(SUB_BLOCKS + 1)
) (
   input logic                         clk_i,
   input logic                         rst_ni,
   input logic                         start_i,
   input logic                         multi_i,
   input logic                         valid_o,
   input logic                         fail_o,
   input logic [CNT_W-1:0]             fix_count_o,
   input logic [SUB_BLOCKS*2-1:0]      sub_state_o,
   input logic [SUB_BLOCKS*OFS_W-1:0]  byte_ofs_o,
   input logic [SUB_BLOCKS*IDX_W-1:0]  bit_idx_o
);
   logic any_bad;
   always_comb begin
      any_bad = 1'b0;
      for (int k = 0; k < SUB_BLOCKS; k++)
         if (sub_state_o[k*2 +: 2] == 2'd3) any_bad = 1'b1;
   end

   // R2
   valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> valid_o);
   // R2
   valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_i |=> !valid_o);
   // R2
   result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_i |=> ($stable(fix_count_o) && $stable(sub_state_o) &&
                    $stable(byte_ofs_o) && $stable(bit_idx_o) && $stable(fail_o)));
   // R8
   fail_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fail_o |-> (fix_count_o == '0));
   // R8
   fail_agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fail_o == any_bad);

   if (SUB_BLOCKS > 1) begin : g_single
      // R9
      single_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (start_i && !multi_i) |=> (sub_state_o[SUB_BLOCKS*2-1:2] == '0));
   end

   for (genvar k = 0; k < SUB_BLOCKS; k++) begin : g_ofs
      // R10
      ofs_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (sub_state_o[k*2 +: 2] != 2'd1) |->
            (byte_ofs_o[k*OFS_W +: OFS_W] == '0 && bit_idx_o[k*IDX_W +: IDX_W] == '0));
   end
endmodule

bind hamming_fix_unit hamming_fix_chk #(.SUB_BLOCKS(SUB_BLOCKS)) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .start_i     (start_i),
   .multi_i     (multi_i),
   .valid_o     (valid_o),
   .fail_o      (fail_o),
   .fix_count_o (fix_count_o),
   .sub_state_o (sub_state_o),
   .byte_ofs_o  (byte_ofs_o),
   .bit_idx_o   (bit_idx_o)
);

// File: tb/hamming_fix_unit_tb_top.sv
`timescale 1ns/1ps
module hamming_fix_unit_tb_top;
   localparam int SB = 4;
   localparam int CW = 24;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic            multi = 1'b0;
   logic [SB*CW-1:0] stored = '0;
   logic [SB*CW-1:0] calc = '0;
   logic            valid, fail;
   logic [2:0]      cnt;
   logic [SB*2-1:0] st;
   logic [SB*9-1:0] ofs;
   logic [SB*3-1:0] idx;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   hamming_fix_unit #(.SUB_BLOCKS(SB)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .multi_i(multi),
      .stored_i(stored), .calc_i(calc), .valid_o(valid), .fail_o(fail),
      .fix_count_o(cnt), .sub_state_o(st), .byte_ofs_o(ofs), .bit_idx_o(idx));

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // raw generator toggles caused by one flipped data bit at address a
   function automatic logic [27:0] toggle_of(input int a);
      logic [27:0] r = '0;
      for (int j = 0; j < 12; j++)
         if (a[j]) r[16+j] = 1'b1; else r[j] = 1'b1;
      return r;
   endfunction

   function automatic logic [23:0] pack(input logic [27:0] r);
      return {r[27:24], r[11:8], r[23:16], r[7:0]};
   endfunction

   task automatic apply(input logic [SB*CW-1:0] s, input logic [SB*CW-1:0] c, input logic m);
      @(negedge clk);
      stored = s; calc = c; multi = m; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // block 0 summary: {valid, fail, cnt, state0, ofs0, idx0}
   function automatic logic [63:0] blk0();
      return 64'({valid, fail, cnt, st[1:0], ofs[8:0], idx[2:0]});
   endfunction

   function automatic logic [63:0] exp0(input logic f, input logic [2:0] c,
                                        input logic [1:0] s, input int o, input int b);
      return 64'({1'b1, f, c, s, o[8:0], b[2:0]});
   endfunction

   initial begin
      logic [SB*CW-1:0] s, c;
      logic [23:0] base;
      repeat (3) @(negedge clk);
      check("R1 reset outputs", 64'({valid, fail, cnt, st, ofs, idx}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", 64'({valid, fail, cnt, st, ofs, idx}), 64'd0);

      // R3 clean
      s = '0; s[23:0] = 24'hA5C31E;
      apply(s, s, 1'b0);
      check("R3 equal codes", blk0(), exp0(1'b0, 3'd0, 2'd0, 0, 0));
      // R2 one-cycle pulse
      @(negedge clk);
      check("R2 valid drops", 64'(valid), 64'd0);

      // R4 exhaustive single data-bit errors in block 0
      for (int a = 0; a < 4096; a++) begin
         base = 24'(a * 24'h9E37) ^ 24'h5A5A5A;
         s = '0; c = '0;
         s[23:0] = base;
         c[23:0] = base ^ pack(toggle_of(a));
         apply(s, c, 1'b0);
         check($sformatf("R4 addr %0d", a), blk0(), exp0(1'b0, 3'd1, 2'd1, a >> 3, a & 7));
      end

      // R2 hold without start while inputs change
      s = '0; c = '0; s[23:0] = 24'h123456; c[23:0] = 24'h123456 ^ pack(toggle_of(1234));
      apply(s, c, 1'b0);
      stored = '1; calc = '0;
      repeat (3) @(negedge clk);
      check("R2 results held", 64'({fail, cnt, st[1:0], ofs[8:0], idx[2:0]}),
            64'({1'b0, 3'd1, 2'd1, 9'(1234 >> 3), 3'(1234 & 7)}));

      // R5 single stored-code bit
      for (int b = 0; b < 24; b++) begin
         s = '0; c = '0; s[23:0] = 24'h3C0F81; c[23:0] = 24'h3C0F81 ^ (24'd1 << b);
         apply(s, c, 1'b0);
         check($sformatf("R5 code bit %0d", b), blk0(), exp0(1'b0, 3'd0, 2'd2, 0, 0));
      end

      // R6 double data errors differing in one address bit (weight 2)
      for (int k = 0; k < 12; k++) begin
         s = '0; c = '0; s[23:0] = 24'h77E102;
         c[23:0] = s[23:0] ^ pack(toggle_of(300) ^ toggle_of(300 ^ (1 << k)));
         apply(s, c, 1'b0);
         check($sformatf("R6 double k=%0d", k), blk0(), exp0(1'b1, 3'd0, 2'd3, 0, 0));
      end
      // R6 weight 23
      s = '0; c = '0; s[23:0] = 24'hFFFFFF; c[23:0] = 24'h000001;
      apply(s, c, 1'b0);
      check("R6 near-erased", blk0(), exp0(1'b1, 3'd0, 2'd3, 0, 0));

      // R7 erased page
      s = '0; c = '0; s[23:0] = 24'hFFFFFF;
      apply(s, c, 1'b0);
      check("R7 erased page", blk0(), exp0(1'b0, 3'd0, 2'd0, 0, 0));

      // R8 multi mode: fixed, clean, fixed, code-only
      s = {24'h111111, 24'h222222, 24'h333333, 24'h444444};
      c = s;
      c[0*CW +: CW] ^= pack(toggle_of(5));
      c[2*CW +: CW] ^= pack(toggle_of(4095));
      c[3*CW +: CW] ^= 24'h000100;
      apply(s, c, 1'b1);
      check("R8 multi count", 64'({valid, fail, cnt, st}), 64'({1'b1, 1'b0, 3'd2, 8'b10_01_00_01}));
      check("R8 multi offsets", 64'({ofs, idx}),
            64'({9'd0, 9'd511, 9'd0, 9'd0, 3'd0, 3'd7, 3'd0, 3'd5}));
      // R8 one block uncorrectable
      c[3*CW +: CW] = s[3*CW +: CW] ^ 24'h000003;
      apply(s, c, 1'b1);
      check("R8 multi fail", 64'({valid, fail, cnt, st}), 64'({1'b1, 1'b1, 3'd0, 8'b11_01_00_01}));
      // R10 offsets of non-fixed blocks stay zero
      check("R10 bad block offset", 64'({ofs[3*9 +: 9], idx[3*3 +: 3]}), 64'd0);

      // R9 single mode ignores upper blocks
      apply(s, c, 1'b0);
      check("R9 single mode", 64'({valid, fail, cnt, st, ofs[35:9], idx[11:3]}),
            64'({1'b1, 1'b0, 3'd1, 8'b00_00_00_01, 27'd0, 9'd0}));

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #1000000;
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule